// File: doc/BRIEF.md
# Operand Load Merge Unit

This unit takes a data word read from memory and merges the operand it holds into a 32-bit destination register. The operand is a byte, a halfword or something at least a word wide. A byte or halfword goes into the low bits of the result. The bits above it come from one of three sources, chosen by the mode: copies of the operand's sign bit, zeros, or the upper bits of the old register value. Operands of 32 bits or more pass the data word through unchanged.

Alongside the result, the unit checks the byte address against the alignment rule for the operand type. A pipeline can use this flag to send the access down a slower path. Alignment usually means the address is a multiple of the operand length. The 48-bit type is the exception: it only needs halfword alignment.

Requests that pair the unsigned or insert mode with a wide type are flagged as illegal, and the old register value is kept. Each request is presented for one cycle with a valid strobe. The result, both flags and a one-cycle valid pulse are registered on the next clock edge.

Top module: `load_merge_unit`

## Requirements
- R1: The operand type code is 0 byte, 1 halfword, 2 word, 3 long, 4 medium (48-bit), 5 floating, 6 double, 7 quad. A byte is taken from data lane `byteAddr[1:0]` (lane k is bits 8k+7..8k) and a halfword from lane `byteAddr[1]` (bits 16h+15..16h), and either is placed in the least significant bits of the result.
- R2: With mode 0 (signed load) and a byte or halfword type, every result bit above the operand equals the operand's top bit.
- R3: With mode 1 (unsigned load) and a byte or halfword type, every result bit above the operand is zero.
- R4: With mode 2 (insert) and a byte or halfword type, every result bit above the operand keeps the value of `oldVal` presented with the request.
- R5: With mode 0 and any type code from 2 to 7, the result equals the whole data word.
- R6: Mode 3, or mode 1 or 2 with any type code from 2 to 7, sets `illegalOp`, and the result equals `oldVal`. Otherwise `illegalOp` is clear.
- R7: For byte, halfword, word, long, floating, double and quad, `misaligned` is set exactly when the byte address is not a multiple of 1, 2, 4, 8, 4, 8 or 16 respectively. This holds in every mode.
- R8: For the medium type, `misaligned` is set exactly when the byte address is odd.
- R9: A request with `inValid` high at one rising edge makes `outValid` high for exactly that following cycle. While no request is taken, `newVal`, `misaligned` and `illegalOp` hold their values.
- R10: After reset, `outValid`, `newVal`, `misaligned` and `illegalOp` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| memData | input | DATA_W (32) | Data word fetched from memory |
| byteAddr | input | ADDR_W (16) | Byte address of the operand |
| opType | input | 3 | Operand type code |
| opMode | input | 2 | Merge mode: 0 signed, 1 unsigned, 2 insert, 3 reserved |
| oldVal | input | DATA_W (32) | Current destination register value |
| outValid | output | 1 | One-cycle result strobe |
| newVal | output | DATA_W (32) | Merged register value |
| misaligned | output | 1 | Operand address violates its type's alignment |
| illegalOp | output | 1 | Mode not permitted for this type |

## Verification
The bench builds the unit with its default 32-bit data word and 16-bit address. At that size the whole control space can be covered in a few thousand cycles: all eight types, all four modes and every value of the low four address bits. Each of those combinations is run against data words whose lanes mix positive and negative byte and halfword values, with two different old register values.

Together these cover:
- every lane selection;
- each of the three fill rules;
- each alignment modulus, including the 16-byte one for quad;
- the halfword-only rule for the 48-bit type.

An idle cycle follows every request, to observe the valid pulse ending and the held outputs.

// File: rtl/ldmerge_pkg.sv
package ldmerge_pkg;

  typedef enum logic [2:0] {
    T_BYTE   = 3'd0,
    T_HALF   = 3'd1,
    T_WORD   = 3'd2,
    T_LONG   = 3'd3,
    T_MEDIUM = 3'd4,
    T_FLOAT  = 3'd5,
    T_DOUBLE = 3'd6,
    T_QUAD   = 3'd7
  } opType_e;

  typedef enum logic [1:0] {
    M_SIGNED   = 2'd0,
    M_UNSIGNED = 2'd1,
    M_INSERT   = 2'd2,
    M_RSVD     = 2'd3
  } opMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic pickByte;   // narrow operand is a byte
    logic pickHalf;   // narrow operand is a halfword
    logic fillSign;   // replicate operand top bit upward
    logic keepUpper;  // retain old register upper bits
    logic illegal;    // mode not allowed for this type
    logic misalign;   // address breaks type alignment
  } mergeCtrl_t;

  // Widest alignment modulus is 16 bytes
  localparam int ALIGN_BITS = 4;

endpackage

// File: rtl/ldmerge_ctrl.sv
module ldmerge_ctrl
  import ldmerge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [2:0]        opType,
  input  logic [1:0]        opMode,
  input  logic [ADDR_W-1:0] byteAddr,
  output mergeCtrl_t        ctrl
);

  logic [ALIGN_BITS-1:0] alignMask;
  logic                  isNarrow;
  logic                  modeNeedsNarrow;

  // Low address bits that must be zero for each type
  always_comb begin
    case (opType)
      T_BYTE:   alignMask = 4'b0000;
      T_HALF:   alignMask = 4'b0001;
      T_WORD:   alignMask = 4'b0011;
      T_LONG:   alignMask = 4'b0111;
      T_MEDIUM: alignMask = 4'b0001;  // halfword boundary suffices
      T_FLOAT:  alignMask = 4'b0011;
      T_DOUBLE: alignMask = 4'b0111;
      T_QUAD:   alignMask = 4'b1111;
      default:  alignMask = 4'b0000;
    endcase
  end

  always_comb begin
    isNarrow        = (opType == T_BYTE) || (opType == T_HALF);
    modeNeedsNarrow = (opMode == M_UNSIGNED) || (opMode == M_INSERT);

    ctrl.pickByte  = (opType == T_BYTE);
    ctrl.pickHalf  = (opType == T_HALF);
    ctrl.fillSign  = (opMode == M_SIGNED);
    ctrl.keepUpper = (opMode == M_INSERT);
    ctrl.illegal   = (opMode == M_RSVD) || (modeNeedsNarrow && !isNarrow);
    ctrl.misalign  = |(byteAddr[ALIGN_BITS-1:0] & alignMask);
  end

endmodule

// File: rtl/ldmerge_datapath.sv
module ldmerge_datapath
  import ldmerge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] memData,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] oldVal,
  input  mergeCtrl_t        ctrl,
  output logic              outValid,
  output logic [DATA_W-1:0] newVal,
  output logic              misaligned,
  output logic              illegalOp
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int HALVES = DATA_W / HALF_W;
  localparam int LSEL_W = $clog2(LANES);
  localparam int HSEL_W = LSEL_W - 1;

  logic [BYTE_W-1:0] byteLane [LANES];
  logic [HALF_W-1:0] halfLane [HALVES];
  logic [BYTE_W-1:0] byteSel;
  logic [HALF_W-1:0] halfSel;
  logic [DATA_W-1:0] merged;

  // Little-endian lane split
  for (genvar gb = 0; gb < LANES; gb++) begin : g_byteLane
    assign byteLane[gb] = memData[gb*BYTE_W +: BYTE_W];
  end
  for (genvar gh = 0; gh < HALVES; gh++) begin : g_halfLane
    assign halfLane[gh] = memData[gh*HALF_W +: HALF_W];
  end

  assign byteSel = byteLane[byteAddr[LSEL_W-1:0]];
  assign halfSel = halfLane[byteAddr[LSEL_W-1:1]];

  always_comb begin
    merged = memData;
    if (ctrl.illegal) begin
      merged = oldVal;
    end else if (ctrl.pickByte) begin
      if (ctrl.keepUpper)
        merged = {oldVal[DATA_W-1:BYTE_W], byteSel};
      else if (ctrl.fillSign)
        merged = {{(DATA_W-BYTE_W){byteSel[BYTE_W-1]}}, byteSel};
      else
        merged = {{(DATA_W-BYTE_W){1'b0}}, byteSel};
    end else if (ctrl.pickHalf) begin
      if (ctrl.keepUpper)
        merged = {oldVal[DATA_W-1:HALF_W], halfSel};
      else if (ctrl.fillSign)
        merged = {{(DATA_W-HALF_W){halfSel[HALF_W-1]}}, halfSel};
      else
        merged = {{(DATA_W-HALF_W){1'b0}}, halfSel};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      newVal     <= '0;
      misaligned <= 1'b0;
      illegalOp  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        newVal     <= merged;
        misaligned <= ctrl.misalign;
        illegalOp  <= ctrl.illegal;
      end
    end
  end

endmodule

// File: rtl/load_merge_unit.sv
module load_merge_unit
  import ldmerge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] memData,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [2:0]        opType,
  input  logic [1:0]        opMode,
  input  logic [DATA_W-1:0] oldVal,
  output logic              outValid,
  output logic [DATA_W-1:0] newVal,
  output logic              misaligned,
  output logic              illegalOp
);

  mergeCtrl_t ctrl;

  ldmerge_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .opType   (opType),
    .opMode   (opMode),
    .byteAddr (byteAddr),
    .ctrl     (ctrl)
  );

  ldmerge_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .memData    (memData),
    .byteAddr   (byteAddr),
    .oldVal     (oldVal),
    .ctrl       (ctrl),
    .outValid   (outValid),
    .newVal     (newVal),
    .misaligned (misaligned),
    .illegalOp  (illegalOp)
  );

endmodule

// File: rtl/ldmerge_chk.sv
module ldmerge_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [ADDR_W-1:0] byteAddr,
  input logic [2:0]        opType,
  input logic [1:0]        opMode,
  input logic [DATA_W-1:0] oldVal,
  input logic              outValid,
  input logic [DATA_W-1:0] newVal,
  input logic              misaligned,
  input logic              illegalOp
);

  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> ($stable(newVal) && $stable(misaligned) && $stable(illegalOp)));

  // R6
  illegal_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && illegalOp) |-> newVal == $past(oldVal));

  // R2
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opType) == 3'd0 && $past(opMode) == 2'd0)
      |-> newVal[DATA_W-1:8] == {(DATA_W-8){newVal[7]}});

  // R3
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opType) == 3'd1 && $past(opMode) == 2'd1)
      |-> newVal[DATA_W-1:16] == '0);

  // R4
  insert_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opType) == 3'd0 && $past(opMode) == 2'd2)
      |-> newVal[DATA_W-1:8] == $past(oldVal[DATA_W-1:8]));

  // R7
  byte_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opType) == 3'd0) |-> !misaligned);

  // R8
  medium_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opType) == 3'd4) |-> misaligned == $past(byteAddr[0]));

endmodule

bind load_merge_unit ldmerge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .byteAddr   (byteAddr),
  .opType     (opType),
  .opMode     (opMode),
  .oldVal     (oldVal),
  .outValid   (outValid),
  .newVal     (newVal),
  .misaligned (misaligned),
  .illegalOp  (illegalOp)
);

// File: tb/load_merge_unit_tb.sv
`timescale 1ns/1ps
module load_merge_unit_tb;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] memData = '0;
  logic [ADDR_W-1:0] byteAddr = '0;
  logic [2:0]        opType = '0;
  logic [1:0]        opMode = '0;
  logic [DATA_W-1:0] oldVal = '0;
  logic              outValid;
  logic [DATA_W-1:0] newVal;
  logic              misaligned;
  logic              illegalOp;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  load_merge_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .memData(memData),
    .byteAddr(byteAddr), .opType(opType), .opMode(opMode), .oldVal(oldVal),
    .outValid(outValid), .newVal(newVal), .misaligned(misaligned),
    .illegalOp(illegalOp)
  );

  task automatic check(string req, string what, logic [DATA_W-1:0] got,
                       logic [DATA_W-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h (type %0d mode %0d addr %h)",
               req, what, got, exp, opType, opMode, byteAddr);
    end
  endtask

  function automatic int alignOf(int t);
    case (t)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      4: return 2;
      5: return 4;
      6: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic string valueReq(int t, int m, bit ill);
    if (ill) return "R6";
    if (t > 1) return "R5";
    if (m == 0) return "R1/R2";
    if (m == 1) return "R1/R3";
    return "R1/R4";
  endfunction

  task automatic runOne(int t, int m, logic [ADDR_W-1:0] a,
                        logic [DATA_W-1:0] d, logic [DATA_W-1:0] o);
    logic [DATA_W-1:0] expVal;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] prevVal;
    bit ill;
    bit mis;
    ill = (m == 3) || ((m == 1 || m == 2) && t > 1);
    mis = (int'(a) % alignOf(t)) != 0;
    if (ill) begin
      expVal = o;
    end else if (t == 0) begin
      q = (d >> (8 * (int'(a) % 4))) & 32'hFF;
      if (m == 0)      expVal = q[7] ? (q | 32'hFFFF_FF00) : q;
      else if (m == 1) expVal = q;
      else             expVal = (o & 32'hFFFF_FF00) | q;
    end else if (t == 1) begin
      q = (d >> (16 * ((int'(a) / 2) % 2))) & 32'hFFFF;
      if (m == 0)      expVal = q[15] ? (q | 32'hFFFF_0000) : q;
      else if (m == 1) expVal = q;
      else             expVal = (o & 32'hFFFF_0000) | q;
    end else begin
      expVal = d;
    end

    @(negedge clk);
    opType   = 3'(t);
    opMode   = 2'(m);
    byteAddr = a;
    memData  = d;
    oldVal   = o;
    inValid  = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R9", "outValid", {31'd0, outValid}, 32'd1);
    check(valueReq(t, m, ill), "newVal", newVal, expVal);
    check((t == 4) ? "R8" : "R7", "misaligned", {31'd0, misaligned}, {31'd0, mis});
    check("R6", "illegalOp", {31'd0, illegalOp}, {31'd0, ill});
    prevVal = newVal;
    // scramble inputs during the idle cycle; nothing may change
    memData = ~d;
    oldVal  = ~o;
    @(negedge clk);
    check("R9", "outValid idle", {31'd0, outValid}, 32'd0);
    check("R9", "newVal hold", newVal, prevVal);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] pats [3];
    logic [DATA_W-1:0] olds [2];
    pats[0] = 32'h80FF_7F01;
    pats[1] = 32'h12F4_9C3B;
    pats[2] = 32'hFFFF_0000;
    olds[0] = 32'hDEAD_BEEF;
    olds[1] = 32'h1357_2468;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "outValid", {31'd0, outValid}, 32'd0);
    check("R10", "newVal", newVal, 32'd0);
    check("R10", "misaligned", {31'd0, misaligned}, 32'd0);
    check("R10", "illegalOp", {31'd0, illegalOp}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 8; t++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < 16; a++) begin
          for (int p = 0; p < 3; p++) begin
            runOne(t, m, ADDR_W'(16'h5A30 + a), pats[p], olds[(a + p) % 2]);
          end
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule